// File: doc/BRIEF.md
# Reciprocal Seed Special-Case Handler

This block sits in front of a single-precision reciprocal-approximation step. It takes a numerator and a denominator word and classifies each one as NaN (quiet or signalling), infinity, zero or finite non-zero. Subnormals count as finite non-zero. When either operand is special, the block forces a fixed result word and the matching exception flags. It also lowers a predicate that tells the downstream iteration to skip the normal refinement path.

When both operands are ordinary finite non-zero values, the block passes the denominator through unchanged, raises the predicate and leaves all flags clear. Results appear one clock after the input is accepted. The outputs hold their last values while no new input arrives.

The flag vector is indexed 5 down to 1:

| Bit | Meaning |
|-----|---------|
| 1 | invalid |
| 2 | divide-by-zero |
| 3 | overflow |
| 4 | underflow |
| 5 | inexact |

Top module: `recip_special_front`

## Requirements
- R1: If either operand is a quiet NaN (exponent 0xFF, mantissa bit 22 set) and neither is a signalling NaN, the result is 0xFFFFFFFF, the flags are all zero and the predicate is low. This holds whatever the other operand is, including zero.
- R2: If either operand is a signalling NaN (exponent 0xFF, bit 22 clear, mantissa non-zero), the result is 0xFFFFFFFF, only flag bit 1 (invalid) is set and the predicate is low. This holds in numerator, denominator or both, and alongside a quiet NaN or a zero denominator.
- R3: A finite non-zero numerator with a zero denominator of either sign gives 0x3F800000, only flag bit 2 (divide-by-zero) set, and the predicate low.
- R4: An infinite numerator with a zero denominator gives 0x3F800000, no flags, and the predicate low.
- R5: Zero divided by zero, and infinity divided by infinity (any signs), give 0xFFFFFFFF with only flag bit 1 set and the predicate low.
- R6: Each of the remaining non-NaN cases that involve a zero or an infinity gives 0x3F800000, no flags, and the predicate low. These cases are:
  - a zero numerator with a non-zero denominator;
  - a finite numerator with an infinite denominator;
  - an infinite numerator with a finite non-zero denominator.
- R7: When both operands are finite and non-zero (subnormals included), the result equals the denominator bit for bit, the predicate is high and the flags are zero.
- R8: Flag bits 3, 4 and 5 (overflow, underflow, inexact) are never set.
- R9: The output valid rises exactly one cycle after each accepted input valid, once per input. Back-to-back inputs give back-to-back outputs. Result, predicate and flags hold while no input is accepted.
- R10: During reset, output valid, result, predicate and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair valid |
| in_num | input | 32 | Numerator, single precision |
| in_den | input | 32 | Denominator, single precision |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Forced special value or passed-through denominator |
| out_pred | output | 1 | High when the normal iterative path applies |
| out_flags | output | 5 | Exception flags, bits 5..1 |

## Verification
Several classification outcomes can apply to the same operand pair. A NaN can sit opposite a zero denominator, a signalling NaN can meet a quiet NaN, and an infinite numerator can meet a zero denominator. In each case only the highest-priority rule may decide the outcome. The bench drives these collisions directly, and back to back with ordinary pairs, so that a stale or merged flag from the previous pair would show. The scoreboard judges each output against the single outcome the priority ordering predicts, checking that the invalid flag wins and divide-by-zero stays clear when a NaN is present.

// File: rtl/recip_special_front.sv
module recip_special_front (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_num,
  input  logic [31:0] in_den,
  output logic        out_valid,
  output logic [31:0] out_result,
  output logic        out_pred,
  output logic [5:1]  out_flags
);

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] ONE_F    = 32'h3F80_0000;

  wire n_emax = &in_num[30:23];
  wire d_emax = &in_den[30:23];
  wire n_mz   = in_num[22:0] == 23'd0;
  wire d_mz   = in_den[22:0] == 23'd0;

  wire n_nan  = n_emax & ~n_mz;
  wire d_nan  = d_emax & ~d_mz;
  wire n_snan = n_nan & ~in_num[22];
  wire d_snan = d_nan & ~in_den[22];
  wire n_inf  = n_emax & n_mz;
  wire d_inf  = d_emax & d_mz;
  wire n_zero = in_num[30:0] == 31'd0;
  wire d_zero = in_den[30:0] == 31'd0;

  logic [31:0] res_c;
  logic        pred_c;
  logic        inv_c;
  logic        dbz_c;

  always_comb begin
    res_c  = ONE_F;
    pred_c = 1'b0;
    inv_c  = 1'b0;
    dbz_c  = 1'b0;
    if (n_nan | d_nan) begin
      res_c = ALL_ONES;
      inv_c = n_snan | d_snan;
    end else if (d_zero) begin
      if (n_zero) begin
        res_c = ALL_ONES;
        inv_c = 1'b1;
      end else begin
        dbz_c = ~n_inf;
      end
    end else if (n_inf & d_inf) begin
      res_c = ALL_ONES;
      inv_c = 1'b1;
    end else if (!(n_zero | n_inf | d_inf)) begin
      res_c  = in_den;
      pred_c = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_pred   <= 1'b0;
      out_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_c;
        out_pred   <= pred_c;
        out_flags  <= {3'b000, dbz_c, inv_c};
      end
    end
  end

endmodule

module recip_special_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_pred,
  input logic [5:1]  out_flags
);

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_pred) && $stable(out_flags)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[5:3] == 3'b000);

  // R7
  pred_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pred) |-> out_flags == 5'b00000);

  // R3
  dbz_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> (out_result == 32'h3F80_0000 && !out_pred));

  // R2
  invalid_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> (out_result == 32'hFFFF_FFFF && !out_pred));

  // R2
  single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_flags));

endmodule

bind recip_special_front recip_special_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_pred   (out_pred),
  .out_flags  (out_flags)
);

// File: tb/test_recip_special_front.sv
module test_recip_special_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_num = '0;
  logic [31:0] in_den = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_pred;
  logic [5:1]  out_flags;

  recip_special_front i_recip_special_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_num(in_num), .in_den(in_den),
    .out_valid(out_valid), .out_result(out_result),
    .out_pred(out_pred), .out_flags(out_flags)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] res;
    logic        pred;
    logic [5:1]  flg;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    seen = 0;
  exp_t  last;

  localparam logic [5:1] F_NONE = 5'b00000;
  localparam logic [5:1] F_INV  = 5'b00001;
  localparam logic [5:1] F_DBZ  = 5'b00010;

  task automatic send(input logic [31:0] n, input logic [31:0] d,
                      input logic [31:0] r, input logic p, input logic [5:1] f,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_num   = n;
    in_den   = d;
    exp_q.push_back('{res: r, pred: p, flg: f});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_num   = $urandom;
      in_den   = $urandom;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected out_valid, actual=1 expected=0");
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_result !== e.res || out_pred !== e.pred || out_flags !== e.flg) begin
            errors++;
            $display("FAIL %s: actual res=%h pred=%b flags=%b expected res=%h pred=%b flags=%b",
                     t, out_result, out_pred, out_flags, e.res, e.pred, e.flg);
          end
        end
        checks++;
        if (out_flags[5:3] !== 3'b000) begin
          errors++;
          $display("FAIL R8: actual flags[5:3]=%b expected=000", out_flags[5:3]);
        end
        last = '{res: out_result, pred: out_pred, flg: out_flags};
        seen = 1'b1;
      end else if (seen) begin
        checks++;
        if (out_result !== last.res || out_pred !== last.pred || out_flags !== last.flg) begin
          errors++;
          $display("FAIL R9: hold actual res=%h pred=%b flags=%b expected res=%h pred=%b flags=%b",
                   out_result, out_pred, out_flags, last.res, last.pred, last.flg);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd0 || out_pred !== 1'b0 || out_flags !== 5'd0) begin
      errors++;
      $display("FAIL R10: actual v=%b res=%h pred=%b flags=%b expected all zero",
               out_valid, out_result, out_pred, out_flags);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 quiet NaN
    send(32'h7FC0_0000, 32'h3F80_0000, 32'hFFFF_FFFF, 1'b0, F_NONE, "R1");
    send(32'h3F80_0000, 32'h7FC0_0000, 32'hFFFF_FFFF, 1'b0, F_NONE, "R1");
    send(32'h7FC0_0000, 32'h7FC0_0000, 32'hFFFF_FFFF, 1'b0, F_NONE, "R1");
    send(32'hFFC0_0001, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, F_NONE, "R1");
    idle(2);
    // R2 signalling NaN
    send(32'h7F80_0001, 32'h3F80_0000, 32'hFFFF_FFFF, 1'b0, F_INV, "R2");
    send(32'h3F80_0000, 32'h7F80_0001, 32'hFFFF_FFFF, 1'b0, F_INV, "R2");
    send(32'h7F80_0001, 32'h7F80_0001, 32'hFFFF_FFFF, 1'b0, F_INV, "R2");
    send(32'h7FC0_0000, 32'hFF80_0001, 32'hFFFF_FFFF, 1'b0, F_INV, "R2");
    send(32'h7FBF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, F_INV, "R2");
    idle(1);
    // R3 finite / zero
    send(32'h885D_C960, 32'h8000_0000, 32'h3F80_0000, 1'b0, F_DBZ, "R3");
    send(32'h3F80_0000, 32'h0000_0000, 32'h3F80_0000, 1'b0, F_DBZ, "R3");
    send(32'h0000_0001, 32'h0000_0000, 32'h3F80_0000, 1'b0, F_DBZ, "R3");
    // R4 infinity / zero
    send(32'h7F80_0000, 32'h0000_0000, 32'h3F80_0000, 1'b0, F_NONE, "R4");
    send(32'hFF80_0000, 32'h8000_0000, 32'h3F80_0000, 1'b0, F_NONE, "R4");
    idle(3);
    // R5 zero/zero, inf/inf
    send(32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, F_INV, "R5");
    send(32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, F_INV, "R5");
    send(32'h7F80_0000, 32'hFF80_0000, 32'hFFFF_FFFF, 1'b0, F_INV, "R5");
    // R6 other specials
    send(32'h0000_0000, 32'h3F80_0000, 32'h3F80_0000, 1'b0, F_NONE, "R6");
    send(32'h3F80_0000, 32'h7F80_0000, 32'h3F80_0000, 1'b0, F_NONE, "R6");
    send(32'h7F80_0000, 32'h4000_0000, 32'h3F80_0000, 1'b0, F_NONE, "R6");
    send(32'h8000_0000, 32'hFF80_0000, 32'h3F80_0000, 1'b0, F_NONE, "R6");
    idle(1);
    // R7 ordinary pass-through
    send(32'h3F80_0000, 32'h4040_0000, 32'h4040_0000, 1'b1, F_NONE, "R7");
    send(32'hC000_0000, 32'h0000_0001, 32'h0000_0001, 1'b1, F_NONE, "R7");
    send(32'h1234_5678, 32'hBF7F_FFFF, 32'hBF7F_FFFF, 1'b1, F_NONE, "R7");
    // collisions back to back with ordinary pairs
    send(32'h7F80_0001, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, F_INV, "R2");
    send(32'h4000_0000, 32'h4100_0000, 32'h4100_0000, 1'b1, F_NONE, "R7");
    send(32'h4000_0000, 32'h8000_0000, 32'h3F80_0000, 1'b0, F_DBZ, "R3");
    send(32'h0080_0000, 32'h807F_FFFF, 32'h807F_FFFF, 1'b1, F_NONE, "R7");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: outputs missing actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000ns;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R9: watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule